// File: doc/BRIEF.md
# Prescaled Auto-Reload Down Timer

This block is a two-stage interval timer. An 8-bit prescaler counts down on one of four count-source strobes, and an 8-bit timer counts down once each time the prescaler wraps. Each stage keeps its own reload value. When a stage passes zero it takes its reload value again and carries on. Each time the timer wraps, the block raises a single-cycle interrupt request. With prescaler setting n and timer setting m, the request therefore recurs every (n+1)×(m+1) selected strobes.

Software reaches the block through a byte-wide register port. The port has a mode register, whose bit 3 is the run control, plus the prescaler and timer registers. Writing a counter register sets its reload value and its live count together. Reading a counter register returns the live count.

The four count sources arrive as single-cycle enable strobes on the system clock: undivided, divided by 8, divided by 32, and a low-speed clock divided by 32. A separate 2-bit select input picks one of them.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the mode register reads 0x00, both counters read 0x00 and `irq` is low.
- R2: A write to address 1 sets both the prescaler reload value and the prescaler count to the written byte, and a read of address 1 returns the live prescaler count.
- R3: A write to address 2 sets both the timer reload value and the timer count to the written byte, and a read of address 2 returns the live timer count.
- R4: Counting happens only while mode bit 3 (address 0) is 1. While that bit is 0, both counts hold and `irq` stays low whatever the strobes do.
- R5: `src_sel` value k makes `src_tick[k]` the only strobe that advances the prescaler (k = 0 undivided, 1 divided by 8, 2 divided by 32, 3 low-speed divided by 32). Pulses on the other three strobes have no effect.
- R6: On each selected strobe while running, the prescaler decrements by one. If it was 0, it takes its reload value instead.
- R7: The timer changes only on a prescaler wrap (prescaler at 0 on a selected strobe). It then decrements by one, or takes its reload value if it was 0.
- R8: `irq` is high for exactly the cycle in which the timer is at 0 and the prescaler wraps. With every strobe selected and the settings held, successive pulses are (n+1)×(m+1) cycles apart.
- R9: Mode register bits 5:0 keep the written value. Bits 7:6 always read 0.
- R10: A register write to a counter in the same cycle as that counter's wrap wins. The stage loads the written byte, reports no wrap, and so causes no timer step (prescaler written) or no `irq` (timer written).
- R11: A read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 mode, 1 prescaler, 2 timer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| src_tick | input | 4 | Count-source enable strobes |
| src_sel | input | 2 | Count-source select |
| irq | output | 1 | Timer underflow interrupt request pulse |

## Verification
A register write can land on a counter in the same cycle that the counter wraps. This is the collision that matters, because it decides whether an `irq` pulse or a timer step is lost. The bench forces the collision directly. It sets both stages to 0 with every strobe selected, so each cycle is a wrap. It then writes the timer, and after that the prescaler, on such a cycle. The cycle-accurate reference model predicts `irq` and the readback for every cycle. A correct design must show no pulse on the write cycle and must show the written byte on the next read. The random phase adds further writes that fall on wrap cycles by chance.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW     = 8;
  localparam int AW     = 2;
  localparam int NSRC   = 4;
  localparam int SELW   = $clog2(NSRC);
  localparam int START_BIT = 3;

  localparam logic [AW-1:0] A_MODE = 2'd0;
  localparam logic [AW-1:0] A_PRE  = 2'd1;
  localparam logic [AW-1:0] A_TMR  = 2'd2;

  // bits 7:6 have no storage
  localparam logic [DW-1:0] MODE_KEEP = 8'h3F;

  // next value of a wrapping down counter
  function automatic logic [DW-1:0] down_next(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  function automatic logic [DW-1:0] read_mux(input logic [AW-1:0] a,
                                             input logic [DW-1:0] mode,
                                             input logic [DW-1:0] pre,
                                             input logic [DW-1:0] tmr);
    case (a)
      A_MODE:  return mode & MODE_KEEP;
      A_PRE:   return pre;
      A_TMR:   return tmr;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_src_mux.sv
module tmr_src_mux #(
  parameter int N    = 4,
  parameter int SELW = 2
) (
  input  logic [N-1:0]    strobes,
  input  logic [SELW-1:0] sel,
  input  logic            run,
  output logic            tick
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign hit[i] = strobes[i] && (sel == SELW'(i));
  end

  assign tick = run && (|hit);
endmodule

// File: rtl/tmr_down_stage.sv
module tmr_down_stage
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] din,
  input  logic          en,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] reload,
  output logic          wrap
);
  assign wrap = en && !ld && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      reload <= '0;
    end else if (ld) begin
      cnt    <= din;
      reload <= din;
    end else if (en) begin
      cnt    <= down_next(cnt, reload);
    end
  end

  // R2 R3 R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(din)) && (reload == $past(din)));

  // R6 R7
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  // R6 R7
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == $past(reload));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> $stable(cnt) && $stable(reload));
endmodule

// File: rtl/tmr_mode_reg.sv
module tmr_mode_reg
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] mode_q,
  output logic          run
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (we) mode_q <= din & MODE_KEEP;
  end

  assign run = mode_q[START_BIT];

  // R9
  mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mode_q[5:0] == $past(din[5:0]) && mode_q[7:6] == 2'b00);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SELW-1:0] src_sel,
  output logic            irq
);
  logic [DW-1:0] mode_q;
  logic          run;
  logic          tick;
  logic          pre_ld, tmr_ld, mode_ld;
  logic [DW-1:0] pre_cnt, pre_rld, tmr_cnt, tmr_rld;
  logic          pre_wrap, tmr_wrap;

  assign mode_ld = bus_we && (bus_addr == A_MODE);
  assign pre_ld  = bus_we && (bus_addr == A_PRE);
  assign tmr_ld  = bus_we && (bus_addr == A_TMR);

  tmr_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_ld), .din(bus_wdata),
    .mode_q(mode_q), .run(run)
  );

  tmr_src_mux #(.N(NSRC), .SELW(SELW)) u_src (
    .strobes(src_tick), .sel(src_sel), .run(run), .tick(tick)
  );

  tmr_down_stage u_pre (
    .clk(clk), .rst_n(rst_n), .ld(pre_ld), .din(bus_wdata), .en(tick),
    .cnt(pre_cnt), .reload(pre_rld), .wrap(pre_wrap)
  );

  tmr_down_stage u_tmr (
    .clk(clk), .rst_n(rst_n), .ld(tmr_ld), .din(bus_wdata), .en(pre_wrap),
    .cnt(tmr_cnt), .reload(tmr_rld), .wrap(tmr_wrap)
  );

  assign irq       = tmr_wrap;
  assign bus_rdata = read_mux(bus_addr, mode_q, pre_cnt, tmr_cnt);

  // R4
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !irq && !pre_wrap);

  // R8
  irq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> tmr_cnt == $past(tmr_rld));

  // R7
  timer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_wrap && !tmr_ld) |=> $stable(tmr_cnt));

  // R10
  write_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ld |-> !irq);
endmodule

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] src_tick = 4'h0;
  logic [1:0] src_sel = 2'd0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  int m_mode = 0, m_pre = 0, m_prl = 0, m_tmr = 0, m_trl = 0;
  int step_no = 0;
  int irq_steps[$];

  prescaled_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
    .src_sel(src_sel), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    case (a)
      0: return m_mode;
      1: return m_pre;
      2: return m_tmr;
      default: return 0;
    endcase
  endfunction

  // one clock: drive at negedge, compare, then advance model at posedge
  task automatic step(input bit we, input int a, input int d,
                      input logic [3:0] tk, input int sel, input string tag);
    bit run, tick, pwr, twr, pre_uf, tmr_uf;
    @(negedge clk);
    bus_we = we; bus_addr = a[1:0]; bus_wdata = d[7:0];
    src_tick = tk; src_sel = sel[1:0];
    run  = (m_mode & 8) != 0;
    tick = run && tk[sel];
    pwr  = we && a == 1;
    twr  = we && a == 2;
    pre_uf = tick && !pwr && m_pre == 0;
    tmr_uf = pre_uf && !twr && m_tmr == 0;
    #1;
    check(tag, "irq", int'(irq), int'(tmr_uf));
    check(tag, "rdata", int'(bus_rdata), model_read(a));
    if (irq) irq_steps.push_back(step_no);
    @(posedge clk);
    step_no++;
    if (we && a == 0) m_mode = d & 'h3F;
    if (pwr) begin m_pre = d; m_prl = d; end
    else if (tick) m_pre = (m_pre == 0) ? m_prl : m_pre - 1;
    if (twr) begin m_tmr = d; m_trl = d; end
    else if (pre_uf) m_tmr = (m_tmr == 0) ? m_trl : m_tmr - 1;
  endtask

  task automatic idle(input int a, input logic [3:0] tk, input int sel, input string tag);
    step(0, a, 0, tk, sel, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) idle(a, 4'h0, 0, "R1");

    // R2 R3 load with counting stopped; R4 strobes do nothing
    step(1, 1, 8'h5A, 4'hF, 0, "R2");
    idle(1, 4'hF, 0, "R2");
    step(1, 2, 8'hC3, 4'hF, 1, "R3");
    idle(2, 4'hF, 1, "R3");
    for (int i = 0; i < 8; i++) idle(i % 3, 4'hF, i % 4, "R4");

    // R9 upper mode bits not kept; R11 unused address
    step(1, 0, 8'hFF, 4'h0, 0, "R9");
    idle(0, 4'h0, 0, "R9");
    idle(3, 4'h0, 0, "R11");
    step(1, 0, 8'hC8, 4'h0, 0, "R9");
    idle(0, 4'h0, 0, "R9");

    // R5 only the selected strobe counts
    step(1, 1, 8'h20, 4'h0, 0, "R5");
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 6; i++) idle(1, ~(4'h1 << s), s, "R5");
      for (int i = 0; i < 3; i++) idle(1, 4'h1 << s, s, "R5");
    end

    // R6 R7 R8 small settings, fast wrap
    step(1, 1, 8'h01, 4'h0, 0, "R6");
    step(1, 2, 8'h02, 4'h0, 0, "R7");
    for (int i = 0; i < 30; i++) idle(i % 3, 4'h1, 0, "R8");

    // R10 collisions: both stages at 0, every strobe a wrap
    step(1, 1, 8'h00, 4'h0, 0, "R10");
    step(1, 2, 8'h00, 4'h0, 0, "R10");
    idle(2, 4'h1, 0, "R10");
    step(1, 2, 8'h05, 4'h1, 0, "R10");
    idle(2, 4'h1, 0, "R10");
    step(1, 2, 8'h00, 4'h0, 0, "R10");
    step(1, 1, 8'h03, 4'h1, 0, "R10");
    idle(1, 4'h1, 0, "R10");
    idle(2, 4'h1, 0, "R10");

    // R8 period (n+1)*(m+1) = 3*4 = 12
    step(1, 1, 8'h02, 4'h0, 0, "R8");
    step(1, 2, 8'h03, 4'h0, 0, "R8");
    irq_steps.delete();
    for (int i = 0; i < 60; i++) idle(2, 4'hF, 0, "R8");
    check("R8", "pulse count", irq_steps.size(), 5);
    for (int i = 1; i < irq_steps.size(); i++)
      check("R8", "pulse spacing", irq_steps[i] - irq_steps[i-1], 12);

    // R6 R7 R10 random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 3) step(1, 1, int'($urandom_range(0, 4)), 4'($urandom), int'($urandom_range(0, 3)), "R10");
      else if (r < 6) step(1, 2, int'($urandom_range(0, 3)), 4'($urandom), int'($urandom_range(0, 3)), "R10");
      else if (r < 7) step(1, 0, (r & 1) ? 8'h00 : 8'h08, 4'($urandom), 0, "R4");
      else idle(int'($urandom_range(0, 3)), 4'($urandom), int'($urandom_range(0, 3)), "R6");
      if (i % 500 == 0) step(1, 0, 8'h08, 4'h0, 0, "R4");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule